// File: doc/BRIEF.md
# Cascadable SPI Switch-Control Slave

This block is a serial slave that sets a bank of switch enables from an 8-bit control word. The word arrives over a four-wire SPI link in mode 0. The clock idles low, the input line is sampled on each rising clock edge and the output line moves on each falling edge. The pins are brought into the local clock domain through synchronizers. Every SPI edge therefore becomes a one-cycle event in that domain. The bits arrive most significant first. The low bits of the control word drive four single-pole single-throw switch enables.

Several copies can sit on one select line and one serial clock. The serial output of each copy feeds the serial input of the next. While select is low, the chain acts as one long shift register, so a device N places from the master receives its word after 8×N clock pulses. When select goes high, every device in the chain copies its shift register into its control word in the same cycle, so all switches change together. At all other times the control word holds its value.

The serial pins are plain SPI wires with no valid/ready handshake. The pace of the stream is set only by the master's clock, and the slave never holds it back.

Top module: `swc_chain_slave`

## Requirements
- R1: After asynchronous reset, `ctrl_word`, `sw_en` and `spi_sdo` are all 0, so every switch is open.
- R2: While `spi_cs_n` is low, each rising edge of `spi_sclk` shifts the `spi_sdi` bit into bit 0 of the internal shift register and moves the earlier bits one place toward bit 7. Bits therefore arrive MSB first, and 8 pulses load a full word.
- R3: `ctrl_word` changes only after a rising edge of `spi_cs_n`. It holds its value throughout a select-low window.
- R4: `spi_sdo` presents bit 7 of the shift register. It is loaded when select falls and again after each falling edge of `spi_sclk`, so a frame first sends the previous contents MSB first and then the received bits.
- R5: In a chain of three devices, a 24-pulse frame puts the first 8 bits sent into the third device, the next 8 into the second device and the last 8 into the first device.
- R6: While `spi_cs_n` is high, activity on `spi_sclk` and `spi_sdi` does not change the shift register or `ctrl_word`, and `spi_sdo` is driven 0.
- R7: If a select-low window does not hold a multiple of 8 pulses, the last 8 bits shifted in are the ones latched when select rises.
- R8: `sw_en[i]` equals `ctrl_word[i]` for i = 0 to 3. Bit 0 drives switch 0.
- R9: The shift register is not cleared when select falls. A select-low window with no clock pulses latches the same contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low (mode 0) |
| spi_cs_n | input | 1 | Active-low select, shared along a chain |
| spi_sdi | input | 1 | Serial data in, from the master or the previous device |
| spi_sdo | output | 1 | Serial data out, to the next device or the master |
| ctrl_word | output | 8 | Latched control word |
| sw_en | output | 4 | Switch enables taken from the low bits of the control word |

## Verification
The bench builds three copies with the default parameters: an 8-bit word, two synchronizer stages and four switches. It links them into a chain and drives them from a behavioural mode-0 master whose SCLK half period is eight local clocks. The chain lets the bench check the 24-pulse delivery of three words. It also lets the bench watch the old contents of each device emerge on the last device's serial output. Short frames of 12, 8 and 0 pulses exercise the partial-word and relatch cases. A stretch of SCLK and SDI toggling with select high exercises the ignore rule.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned PIN_W = 3;
  localparam int unsigned PIN_SCLK = 2;
  localparam int unsigned PIN_CSN  = 1;
  localparam int unsigned PIN_SDI  = 0;
  // idle pin levels: clock low, select high, data low
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_shifter.sv
module swc_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_d, cs_n_d;
  logic              ev_rise, ev_fall, ev_sel, ev_desel;
  logic [WORD_W-1:0] shift_q, word_q;
  logic              sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_n_d <= cs_n_s;
    end
  end

  // SCLK edges count only while selected
  assign ev_rise  = sclk_s & ~sclk_d & ~cs_n_s;
  assign ev_fall  = ~sclk_s & sclk_d & ~cs_n_s;
  assign ev_sel   = ~cs_n_s & cs_n_d;
  assign ev_desel = cs_n_s & ~cs_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (ev_rise) shift_q <= {shift_q[WORD_W-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_q <= 1'b0;
    else if (ev_sel || ev_fall) sdo_q <= shift_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (ev_desel) word_q <= shift_q;
  end

  assign sdo_o  = cs_n_s ? 1'b0 : sdo_q;
  assign word_o = word_q;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> shift_q == {$past(shift_q[WORD_W-2:0]), $past(sdi_s)}); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_desel |=> $stable(word_q)); // R3
  AST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> word_q == $past(shift_q)); // R7
  AST_SDO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> sdo_q == $past(shift_q[WORD_W-1])); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(shift_q)); // R6
endmodule

// File: rtl/swc_chain_slave.sv
module swc_chain_slave #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SW_COUNT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_sdi,
  output logic                spi_sdo,
  output logic [WORD_W-1:0]   ctrl_word,
  output logic [SW_COUNT-1:0] sw_en
);
  import swc_pkg::*;

  logic [PIN_W-1:0] pins_raw, pins_s;

  assign pins_raw[PIN_SCLK] = spi_sclk;
  assign pins_raw[PIN_CSN]  = spi_cs_n;
  assign pins_raw[PIN_SDI]  = spi_sdi;

  swc_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  swc_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[PIN_SCLK]), .cs_n_s(pins_s[PIN_CSN]), .sdi_s(pins_s[PIN_SDI]),
    .sdo_o(spi_sdo), .word_o(ctrl_word)
  );

  assign sw_en = ctrl_word[SW_COUNT-1:0];

  initial begin
    assert (SW_COUNT <= WORD_W) else $error("SW_COUNT exceeds WORD_W"); // R8
  end
  AST_RESET_OPEN: assert property (@(posedge clk) $rose(rst_n) |-> sw_en == '0); // R1
endmodule

// File: tb/swc_chain_slave_bench.sv
module swc_chain_slave_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int NDEV  = 3;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic       link [0:NDEV];
  logic [7:0] ctrl [NDEV];
  logic [3:0] sw   [NDEV];

  logic [7:0] msh [NDEV];
  logic [7:0] exp_ctrl [NDEV];
  logic [7:0] pend_val [NDEV];
  int pend = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign link[0] = mosi;

  genvar g;
  generate
    for (g = 0; g < NDEV; g++) begin : g_dev
      swc_chain_slave u_swc_chain_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_sdi(link[g]), .spi_sdo(link[g+1]), .ctrl_word(ctrl[g]), .sw_en(sw[g])
      );
    end
  endgenerate

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // latched value becomes visible LAT clocks after select rises
  always @(posedge clk) begin
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) for (int i = 0; i < NDEV; i++) exp_ctrl[i] <= pend_val[i];
    end
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < NDEV; i++)
        check(ctrl[i] == exp_ctrl[i], "R3", $sformatf("dev%0d ctrl per-clock", i),
              ctrl[i], exp_ctrl[i]);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    mosi = b;
    wait_n(HALF/2);
    sclk = 1'b1;
    for (int i = NDEV-1; i >= 0; i--)
      msh[i] = {msh[i][6:0], (i == 0) ? b : msh[i-1][7]};
    wait_n(HALF);
    sclk = 1'b0;
    wait_n(HALF/2);
    check(link[NDEV] == msh[NDEV-1][7], "R4", "chain sdo after fall",
          link[NDEV], msh[NDEV-1][7]);
  endtask

  task automatic frame(input int nbits, input logic [31:0] bits);
    cs_n = 1'b0;
    wait_n(HALF);
    check(link[NDEV] == msh[NDEV-1][7], "R4", "chain sdo after select fall",
          link[NDEV], msh[NDEV-1][7]);
    for (int k = 0; k < nbits; k++) begin
      pulse(bits[nbits-1-k]);
      if (k == nbits/2)
        check(ctrl[0] == exp_ctrl[0], "R3", "dev0 mid-frame unchanged", ctrl[0], exp_ctrl[0]);
    end
    wait_n(HALF);
    cs_n = 1'b1;
    for (int i = 0; i < NDEV; i++) pend_val[i] = msh[i];
    pend = LAT;
    wait_n(LAT + 4);
    check(link[NDEV] == 1'b0, "R6", "sdo low when deselected", link[NDEV], 0);
  endtask

  task automatic expect3(input string req, input logic [23:0] v);
    check(ctrl[2] == v[23:16], req, "dev2 word", ctrl[2], v[23:16]);
    check(ctrl[1] == v[15:8],  req, "dev1 word", ctrl[1], v[15:8]);
    check(ctrl[0] == v[7:0],   req, "dev0 word", ctrl[0], v[7:0]);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < NDEV; i++) begin
      msh[i] = '0; exp_ctrl[i] = '0; pend_val[i] = '0;
    end
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    // R1: reset state
    for (int i = 0; i < NDEV; i++) begin
      check(ctrl[i] == 8'h00, "R1", "ctrl after reset", ctrl[i], 0);
      check(sw[i] == 4'h0, "R1", "sw_en after reset", sw[i], 0);
    end
    check(link[NDEV] == 1'b0, "R1", "sdo after reset", link[NDEV], 0);
    cmp_on = 1'b1;

    // R5: 24-pulse frame loads all three devices
    frame(24, 32'h00A53C81);
    expect3("R5", 24'hA53C81);
    check(sw[0] == 4'h1, "R8", "dev0 switch enables", sw[0], 4'h1);
    check(sw[1] == 4'hC, "R8", "dev1 switch enables", sw[1], 4'hC);

    // R4/R5: second frame pushes old words out MSB first
    frame(24, 32'h005AC37E);
    expect3("R5", 24'h5AC37E);
    check(sw[2] == 4'hA, "R8", "dev2 switch enables", sw[2], 4'hA);

    // R6: activity while deselected is ignored
    for (int k = 0; k < 10; k++) begin
      mosi = k[0];
      wait_n(3);
      sclk = 1'b1;
      wait_n(3);
      sclk = 1'b0;
      check(link[NDEV] == 1'b0, "R6", "sdo during idle toggling", link[NDEV], 0);
    end
    mosi = 1'b0;
    wait_n(6);
    expect3("R6", 24'h5AC37E);

    // R9: empty window relatches untouched shift contents
    frame(0, 32'h0);
    expect3("R9", 24'h5AC37E);

    // R7: partial windows keep the last bits shifted in
    frame(12, 32'h00000FED);
    expect3("R7", 24'h37EFED);

    // R2: 8 pulses fill one word, MSB first
    frame(8, 32'h00000096);
    expect3("R2", 24'hEFED96);
    check(sw[0] == 4'h6, "R8", "dev0 switch enables after byte", sw[0], 4'h6);

    frame(3, 32'h00000005);
    expect3("R7", 24'h7F6CB5);

    cmp_on = 1'b0;
    finish_up();
  end
endmodule